// File: doc/BRIEF.md
# Single-Bit Test and Modify Unit

This unit examines one bit of an operand that has already been fetched. It can then leave the operand alone, invert that bit, force it low or force it high. The caller supplies five things with a valid strobe:

- the operand;
- a bit number;
- a two-bit operation code;
- a flag that marks the target as a 32-bit data register or as a memory byte;
- a flag that says whether the bit number came from a register or was given as an immediate.

One clock later the unit presents four things together with a one-cycle done pulse:

- the modified operand;
- a write-back enable;
- the condition flags, with the zero flag recomputed;
- the number of execution cycles the operation costs.

Address generation and bus traffic belong to the surrounding datapath. The unit only signals that a write-back is needed. For a memory target only the low byte of the operand takes part. The bit number is then reduced modulo 8, where a register target reduces it modulo 32. The zero flag always describes the selected bit as it was before modification. The other four flags pass through untouched.

Top module: `bitop_unit`

## Requirements
- R1: Operation code 0 means test. Code 1 toggles the selected bit, code 2 clears it and code 3 sets it. A test returns the operand unmodified and never raises `wr_en`.
- R2: When `tgt_reg` is 1 the whole 32-bit operand is used and the bit index is `bit_num` modulo 32.
- R3: When `tgt_reg` is 0 only `operand[7:0]` is used. The bit index is `bit_num` modulo 8, and `result[31:8]` is zero.
- R4: `ccr_out[2]` (zero flag) is 1 exactly when the selected bit of the operand was 0 before any modification.
- R5: `ccr_out` bits 4, 3, 1 and 0 are copies of the matching `ccr_in` bits captured with the request.
- R6: For codes 1, 2 and 3 the result differs from the operand only in the selected bit (inverted, 0 or 1 respectively), and `wr_en` is 1 in the done cycle.
- R7: With `num_from_reg`=1, toggle and set cost 8 cycles. Test costs 4 and clear costs 8, each plus 2 when `tgt_reg`=1.
- R8: With `num_from_reg`=0, toggle and set cost 12 cycles. Test costs 8 and clear costs 12, each plus 2 when `tgt_reg`=1.
- R9: All outputs update on the first rising clock edge where `in_valid` is 1. `done` is high for that one cycle. In a cycle without `in_valid`, `done` and `wr_en` are 0 and `result`, `ccr_out` and `cycles` hold their values whatever the other inputs do.
- R10: During reset `done`, `wr_en`, `result`, `ccr_out` and `cycles` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe, one request per cycle |
| operand | input | 32 | Fetched operand (low byte for memory targets) |
| bit_num | input | 8 | Requested bit number before reduction |
| op | input | 2 | 0 test, 1 toggle, 2 clear, 3 set |
| tgt_reg | input | 1 | 1 = 32-bit register target, 0 = memory byte target |
| num_from_reg | input | 1 | 1 = bit number from register, 0 = immediate |
| ccr_in | input | 5 | Flags in: X[4] N[3] Z[2] V[1] C[0] |
| result | output | 32 | Modified operand |
| wr_en | output | 1 | Write-back required, valid with done |
| ccr_out | output | 5 | Flags out, Z replaced, others copied |
| cycles | output | 5 | Execution cycle cost of the request |
| done | output | 1 | One-cycle pulse marking new outputs |

## Verification
The zero-flag update and the bit modification fall into the same result cycle. The flag has to be taken from the operand before the write-back value replaces it. Every code is driven on bits that start both at 0 and at 1, including setting a bit that is already set and clearing one that is already clear. The zero flag is judged against the incoming operand, while the result is judged against the expected modified value. The second overlap is a new request arriving in the same cycle as the done pulse of the previous one. Streams of back-to-back requests provoke it, and a scoreboard pairs each done with its own request.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    typedef enum logic [1:0] {
        BOP_TEST = 2'd0,
        BOP_FLIP = 2'd1,
        BOP_CLR  = 2'd2,
        BOP_SET  = 2'd3
    } bop_e;

    // Flag positions inside the condition vector
    localparam int FLG_X = 4;
    localparam int FLG_N = 3;
    localparam int FLG_Z = 2;
    localparam int FLG_V = 1;
    localparam int FLG_C = 0;

    // Cycle cost constants
    localparam int CYC_W          = 5;
    localparam int CYC_RSRC_TEST  = 4;
    localparam int CYC_RSRC_MOD   = 8;
    localparam int CYC_ISRC_TEST  = 8;
    localparam int CYC_ISRC_MOD   = 12;
    localparam int CYC_REG_EXTRA  = 2;

endpackage

// File: rtl/bitop_mask.sv
// One-hot selector for the addressed bit, reduced by target kind.
module bitop_mask #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int NUM_W  = 8
) (
    input  logic [NUM_W-1:0]  bit_num,
    input  logic              tgt_reg,
    output logic [DATA_W-1:0] mask
);
    localparam int REG_IDX_W = $clog2(DATA_W);
    localparam int MEM_IDX_W = $clog2(BYTE_W);

    logic [REG_IDX_W-1:0] reg_idx;
    logic [MEM_IDX_W-1:0] mem_idx;

    assign reg_idx = bit_num[REG_IDX_W-1:0];
    assign mem_idx = bit_num[MEM_IDX_W-1:0];

    for (genvar i = 0; i < DATA_W; i++) begin : g_sel
        if (i < BYTE_W) begin : g_low
            assign mask[i] = tgt_reg ? (reg_idx == REG_IDX_W'(i))
                                     : (mem_idx == MEM_IDX_W'(i));
        end else begin : g_high
            assign mask[i] = tgt_reg & (reg_idx == REG_IDX_W'(i));
        end
    end

endmodule

// File: rtl/bitop_alu.sv
// Applies the selected operation to the operand and derives the zero flag.
module bitop_alu
    import bitop_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] mask,
    input  bop_e              op,
    input  logic              tgt_reg,
    output logic [DATA_W-1:0] result,
    output logic              bit_zero,
    output logic              writes
);
    logic [DATA_W-1:0] keep;
    logic [DATA_W-1:0] src;

    for (genvar i = 0; i < DATA_W; i++) begin : g_keep
        if (i < BYTE_W) begin : g_byte
            assign keep[i] = 1'b1;
        end else begin : g_upper
            assign keep[i] = tgt_reg;
        end
    end

    assign src      = operand & keep;
    assign bit_zero = ((src & mask) == '0);

    always_comb begin
        unique case (op)
            BOP_FLIP: result = src ^ mask;
            BOP_CLR:  result = src & ~mask;
            BOP_SET:  result = src | mask;
            default:  result = src;
        endcase
        writes = (op != BOP_TEST);
    end

endmodule

// File: rtl/bitop_timing.sv
// Cycle cost of a request.
module bitop_timing
    import bitop_pkg::*;
(
    input  bop_e             op,
    input  logic             tgt_reg,
    input  logic             num_from_reg,
    output logic [CYC_W-1:0] cycles
);
    logic [CYC_W-1:0] base;
    logic [CYC_W-1:0] extra;

    always_comb begin
        if (num_from_reg) begin
            base = (op == BOP_TEST) ? CYC_W'(CYC_RSRC_TEST) : CYC_W'(CYC_RSRC_MOD);
        end else begin
            base = (op == BOP_TEST) ? CYC_W'(CYC_ISRC_TEST) : CYC_W'(CYC_ISRC_MOD);
        end
        extra = (tgt_reg && (op == BOP_TEST || op == BOP_CLR))
              ? CYC_W'(CYC_REG_EXTRA) : '0;
        cycles = base + extra;
    end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int NUM_W  = 8,
    parameter int FLAG_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] operand,
    input  logic [NUM_W-1:0]  bit_num,
    input  logic [1:0]        op,
    input  logic              tgt_reg,
    input  logic              num_from_reg,
    input  logic [FLAG_W-1:0] ccr_in,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic [FLAG_W-1:0] ccr_out,
    output logic [CYC_W-1:0]  cycles,
    output logic              done
);
    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              we;
        logic [FLAG_W-1:0] flg;
        logic [CYC_W-1:0]  cyc;
        logic              dn;
    } state_s;

    bop_e              op_e;
    logic [DATA_W-1:0] sel_mask;
    logic [DATA_W-1:0] alu_res;
    logic              alu_zero;
    logic              alu_writes;
    logic [CYC_W-1:0]  cost;

    state_s st_d;
    state_s st_q;

    assign op_e = bop_e'(op);

    bitop_mask #(
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W),
        .NUM_W  (NUM_W)
    ) u_mask (
        .bit_num (bit_num),
        .tgt_reg (tgt_reg),
        .mask    (sel_mask)
    );

    bitop_alu #(
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W)
    ) u_alu (
        .operand  (operand),
        .mask     (sel_mask),
        .op       (op_e),
        .tgt_reg  (tgt_reg),
        .result   (alu_res),
        .bit_zero (alu_zero),
        .writes   (alu_writes)
    );

    bitop_timing u_timing (
        .op           (op_e),
        .tgt_reg      (tgt_reg),
        .num_from_reg (num_from_reg),
        .cycles       (cost)
    );

    always_comb begin
        st_d    = st_q;
        st_d.dn = in_valid;
        st_d.we = in_valid & alu_writes;
        if (in_valid) begin
            st_d.res        = alu_res;
            st_d.flg        = ccr_in;
            st_d.flg[FLG_Z] = alu_zero;
            st_d.cyc        = cost;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result  = st_q.res;
    assign wr_en   = st_q.we;
    assign ccr_out = st_q.flg;
    assign cycles  = st_q.cyc;
    assign done    = st_q.dn;

endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] operand,
    input logic [1:0]  op,
    input logic        tgt_reg,
    input logic        num_from_reg,
    input logic [4:0]  ccr_in,
    input logic [31:0] result,
    input logic        wr_en,
    input logic [4:0]  ccr_out,
    input logic [4:0]  cycles,
    input logic        done
);
    assert_done_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!done && !wr_en));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(cycles) && $stable(ccr_out)));

    assert_test_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'd0) |=> !wr_en);

    assert_modify_writes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op != 2'd0) |=> wr_en);

    assert_one_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && tgt_reg) |=> ($countones(result ^ $past(operand)) <= 1));

    assert_mem_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !tgt_reg) |=> (result[31:8] == 24'd0));

    assert_flags_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ({ccr_out[4:3], ccr_out[1:0]} == $past({ccr_in[4:3], ccr_in[1:0]})));

    assert_set_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && tgt_reg && op == 2'd3) |=> (ccr_out[2] == (result != $past(operand))));

    assert_regsrc_mod_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && num_from_reg && op[0]) |=> (cycles == 5'd8));

    assert_immsrc_mod_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !num_from_reg && op[0]) |=> (cycles == 5'd12));

endmodule

bind bitop_unit bitop_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .operand      (operand),
    .op           (op),
    .tgt_reg      (tgt_reg),
    .num_from_reg (num_from_reg),
    .ccr_in       (ccr_in),
    .result       (result),
    .wr_en        (wr_en),
    .ccr_out      (ccr_out),
    .cycles       (cycles),
    .done         (done)
);

// File: tb/sim_bitop_unit.sv
`timescale 1ns/100ps
module sim_bitop_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] operand = '0;
    logic [7:0]  bit_num = '0;
    logic [1:0]  op = '0;
    logic        tgt_reg = 1'b0;
    logic        num_from_reg = 1'b0;
    logic [4:0]  ccr_in = '0;
    logic [31:0] result;
    logic        wr_en;
    logic [4:0]  ccr_out;
    logic [4:0]  cycles;
    logic        done;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [31:0] seed = 32'h1234_5678;

    typedef struct {
        logic [31:0] res;
        logic        we;
        logic [4:0]  flg;
        logic [4:0]  cyc;
        int          opc;
        bit          tgt;
        bit          src;
    } exp_t;

    exp_t q[$];
    logic [31:0] last_res = '0;
    logic [4:0]  last_flg = '0;
    logic [4:0]  last_cyc = '0;

    always #2.5 clk = ~clk;

    bitop_unit u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .operand      (operand),
        .bit_num      (bit_num),
        .op           (op),
        .tgt_reg      (tgt_reg),
        .num_from_reg (num_from_reg),
        .ccr_in       (ccr_in),
        .result       (result),
        .wr_en        (wr_en),
        .ccr_out      (ccr_out),
        .cycles       (cycles),
        .done         (done)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] next_rand();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    // Reference model built from the requirements
    function automatic exp_t model(input int o, input bit t, input bit s,
                                   input logic [7:0] n, input logic [31:0] v,
                                   input logic [4:0] f);
        exp_t e;
        int idx;
        logic [31:0] sv;
        logic [31:0] m;
        idx = t ? int'(n % 32) : int'(n % 8);
        sv  = t ? v : (v & 32'hFF);
        m   = 32'd1 << idx;
        case (o)
            1: e.res = sv ^ m;
            2: e.res = sv & ~m;
            3: e.res = sv | m;
            default: e.res = sv;
        endcase
        e.we  = (o != 0);
        e.flg = f;
        e.flg[2] = ((sv & m) == 0);
        if (s) e.cyc = (o == 0) ? 5'd4 : 5'd8;
        else   e.cyc = (o == 0) ? 5'd8 : 5'd12;
        if (t && (o == 0 || o == 2)) e.cyc = e.cyc + 5'd2;
        e.opc = o;
        e.tgt = t;
        e.src = s;
        return e;
    endfunction

    task automatic drive(input int o, input bit t, input bit s,
                         input logic [7:0] n, input logic [31:0] v, input logic [4:0] f);
        @(negedge clk);
        in_valid     = 1'b1;
        op           = o[1:0];
        tgt_reg      = t;
        num_from_reg = s;
        bit_num      = n;
        operand      = v;
        ccr_in       = f;
        q.push_back(model(o, t, s, n, v, f));
    endtask

    task automatic idle(input int cnt);
        for (int i = 0; i < cnt; i++) begin
            @(negedge clk);
            in_valid     = 1'b0;
            operand      = next_rand();
            bit_num      = next_rand() & 32'hFF;
            op           = next_rand() & 32'h3;
            tgt_reg      = seed[3];
            num_from_reg = seed[7];
            ccr_in       = next_rand() & 32'h1F;
        end
    endtask

    // Monitor: samples 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        if (rst_n && !finished) begin
            if (done) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R9 unexpected done", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(result == e.res, e.tgt ? "R2 result" : "R3 result", result, e.res);
                    chk(wr_en == e.we, (e.opc == 0) ? "R1 wr_en" : "R6 wr_en",
                        {31'd0, wr_en}, {31'd0, e.we});
                    chk(ccr_out[2] == e.flg[2], "R4 zero flag",
                        {31'd0, ccr_out[2]}, {31'd0, e.flg[2]});
                    chk(ccr_out == e.flg, "R5 flags", {27'd0, ccr_out}, {27'd0, e.flg});
                    chk(cycles == e.cyc, e.src ? "R7 cycles" : "R8 cycles",
                        {27'd0, cycles}, {27'd0, e.cyc});
                    last_res = e.res;
                    last_flg = e.flg;
                    last_cyc = e.cyc;
                end
            end else begin
                if (q.size() != 0) chk(1'b0, "R9 missing done", 32'd0, 32'd1);
                chk(!wr_en, "R9 idle wr_en", {31'd0, wr_en}, 32'd0);
                chk(result == last_res && ccr_out == last_flg && cycles == last_cyc,
                    "R9 held result", result, last_res);
            end
        end
    end

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            bad++;
            total++;
            $display("FAIL R9 watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(done == 1'b0 && wr_en == 1'b0, "R10 reset done/wr_en", {30'd0, done, wr_en}, 32'd0);
        chk(result == 32'd0, "R10 reset result", result, 32'd0);
        chk(ccr_out == 5'd0 && cycles == 5'd0, "R10 reset flags/cycles",
            {22'd0, ccr_out, cycles}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // Sweep every code, target kind and bit-number source
        for (int o = 0; o < 4; o++) begin
            for (int t = 0; t < 2; t++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int n = 0; n < 64; n++) begin
                        drive(o, t[0], s[0], 8'(n * 5 + t), next_rand(), 5'(next_rand()));
                        if ((n % 9) == 8) idle(1 + (n % 3));
                    end
                end
            end
        end
        idle(3);

        // Corner cases
        drive(3, 1'b1, 1'b1, 8'd31, 32'h0000_0000, 5'b11011); // R6 set top bit, R4 Z=1
        drive(3, 1'b1, 1'b0, 8'd31, 32'h8000_0000, 5'b00000); // R4 set already set: Z=0
        drive(2, 1'b1, 1'b1, 8'd32, 32'hFFFF_FFFE, 5'b10101); // R2 32 wraps to 0
        drive(1, 1'b0, 1'b0, 8'd39, 32'hFFFF_FF00, 5'b01010); // R3 39 -> 7, upper dropped
        drive(2, 1'b0, 1'b1, 8'd255, 32'hFFFF_FFFF, 5'b11111); // R3 255 -> 7
        drive(0, 1'b0, 1'b0, 8'd12, 32'h0000_1000, 5'b00100); // R1 test mem, 12 -> 4
        drive(0, 1'b1, 1'b0, 8'd12, 32'h0000_1000, 5'b11011); // R1 test reg bit 12 set
        drive(1, 1'b1, 1'b1, 8'd200, 32'h0000_0100, 5'b00000); // R2 200 -> 8, toggle off
        idle(4);

        chk(q.size() == 0, "R9 drained", q.size(), 32'd0);
        finished = 1;
        summary();
        $finish;
    end

endmodule